// File: doc/BRIEF.md
# Offset-Binary Signed Multiplier

This block takes two N-bit two's-complement operands and forms their exact 2N-bit two's-complement product. It does not test signs and it never negates an operand under a condition. Each operand has its top bit flipped, which turns it into an unsigned value biased by half the operand range. An unsigned N-by-N core multiplies the two biased values. Two adders then remove the bias. They subtract the operand sum shifted up by N-1 places, and they subtract a fixed constant whose single set bit lies one place below the product's top bit.

The block has no handshake. A new operand pair may be presented on every cycle and a product comes out on every cycle, so there is no back-pressure to manage. The parameter `REGISTERED` selects the output mode. When it is set, a flop stage delays the product by one clock, and a synchronous reset clears that stage to zero. When it is clear, the product follows the operands combinationally. `WIDTH` must be at least 2.

Top module: `offset_signed_mult`

## Requirements
- R1: For any operands x and y, `prod_out` equals x·y as a 2N-bit two's-complement value.
- R2: The most negative operand times itself, -2^(N-1) · -2^(N-1), gives +2^(2N-2) with the top bit clear (0x4000 for N=8).
- R3: The most negative operand times the most positive, -2^(N-1) · (2^(N-1)-1), gives -(2^(2N-2) - 2^(N-1)) (0xC080 for N=8), in either operand order.
- R4: When either operand is zero, the product is all zeros.
- R5: With N=8, -60 · 50 gives the bit pattern 62536 (0xF448), not the 9800 that raw unsigned multiplication would give. Also, -3 · 3 gives -9 (0xFFF7).
- R6: In registered mode, the product for the operands present at a rising edge appears after that edge. It stays unchanged until the next rising edge.
- R7: In registered mode, when `rst` is high at a rising edge, the product is zero after that edge, whatever the operands are.
- R8: When both operands are nonzero, the product's top bit equals the XOR of the two operands' top bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| x_in | input | WIDTH | First two's-complement operand |
| y_in | input | WIDTH | Second two's-complement operand |
| prod_out | output | 2*WIDTH | Two's-complement product |

## Verification
Each test pattern targets a specific way the bias correction can go wrong.

- The extreme pairs (minimum times minimum, minimum times maximum in both orders) push the biased operands to 0 and to 2^N-1. These cases catch a wrong sign extension of the operand sum and a wrong placement of the constant.
- The -60·50 and -3·3 pairs separate a correct correction from one left out, because the raw unsigned product differs in the upper bits.
- Zero operands and a spread of random pairs check the general identity and the sign rule.
- Back-to-back pairs and a reset asserted in the middle of the stream separate a correct one-cycle stage from a missing or doubled one.

// File: rtl/osm_pkg.sv
package osm_pkg;
  localparam int unsigned OSM_DEFAULT_WIDTH = 8;

  // Lowest legal operand width for the bias identity to hold.
  localparam int unsigned OSM_MIN_WIDTH = 2;
endpackage

// File: rtl/osm_bias_flip.sv
// Converts a two's-complement operand into its offset-binary form.
module osm_bias_flip #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] twos_i,
  output logic [WIDTH-1:0] biased_o
);
  generate
    if (WIDTH > 1) begin : g_wide
      assign biased_o = {~twos_i[WIDTH-1], twos_i[WIDTH-2:0]};
    end else begin : g_narrow
      assign biased_o = ~twos_i;
    end
  endgenerate
endmodule

// File: rtl/osm_unsigned_core.sv
// Plain unsigned shift-and-add array, WIDTH x WIDTH -> 2*WIDTH.
module osm_unsigned_core #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] p_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] acc [0:WIDTH];

  assign a_ext  = {{WIDTH{1'b0}}, a_i};
  assign acc[0] = '0;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_row
      logic [PW-1:0] partial;
      assign partial    = b_i[i] ? (a_ext << i) : '0;
      assign acc[i + 1] = acc[i] + partial;
    end
  endgenerate

  assign p_o = acc[WIDTH];
endmodule

// File: rtl/osm_bias_fix.sv
// Removes the offset cross terms and constant from the biased product.
module osm_bias_fix #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]   x_i,
  input  logic [WIDTH-1:0]   y_i,
  input  logic [2*WIDTH-1:0] raw_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int unsigned PW = 2 * WIDTH;
  localparam int unsigned SW = PW + 1;
  localparam logic [PW-1:0] BIAS_SQ = {2'b01, {(PW-2){1'b0}}};

  logic [SW-1:0] x_sx;
  logic [SW-1:0] y_sx;
  logic [SW-1:0] pair_sum;
  logic [SW-1:0] cross_wide;
  logic [PW-1:0] cross_term;

  assign x_sx       = {{(WIDTH+1){x_i[WIDTH-1]}}, x_i};
  assign y_sx       = {{(WIDTH+1){y_i[WIDTH-1]}}, y_i};
  assign pair_sum   = x_sx + y_sx;
  assign cross_wide = pair_sum << (WIDTH - 1);
  assign cross_term = cross_wide[PW-1:0];
  assign prod_o     = raw_i - cross_term - BIAS_SQ;

  always_comb begin
    if (!$isunknown({x_i, y_i, prod_o})) begin
      if (x_i == '0 || y_i == '0)
        assert_zero_operand_R4: assert (prod_o == '0)
          else $error("zero operand gave nonzero product");
      if (x_i != '0 && y_i != '0)
        assert_sign_rule_R8: assert (prod_o[PW-1] == (x_i[WIDTH-1] ^ y_i[WIDTH-1]))
          else $error("product sign disagrees with operand signs");
      if (x_i == {1'b1, {(WIDTH-1){1'b0}}} && y_i == {1'b1, {(WIDTH-1){1'b0}}})
        assert_min_squared_R2: assert (prod_o == BIAS_SQ)
          else $error("min times min wrong");
    end
  end
endmodule

// File: rtl/offset_signed_mult.sv
module offset_signed_mult
  import osm_pkg::*;
#(
  parameter int unsigned WIDTH      = OSM_DEFAULT_WIDTH,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WIDTH-1:0]     x_in,
  input  logic [WIDTH-1:0]     y_in,
  output logic [2*WIDTH-1:0]   prod_out
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [WIDTH-1:0] x_biased;
  logic [WIDTH-1:0] y_biased;
  logic [PW-1:0]    raw_prod;
  logic [PW-1:0]    fixed_prod;

  initial begin
    width_ok_R1: assert (WIDTH >= OSM_MIN_WIDTH)
      else $error("WIDTH below minimum");
  end

  osm_bias_flip #(.WIDTH(WIDTH)) flip_x_i (.twos_i(x_in), .biased_o(x_biased));
  osm_bias_flip #(.WIDTH(WIDTH)) flip_y_i (.twos_i(y_in), .biased_o(y_biased));

  osm_unsigned_core #(.WIDTH(WIDTH)) core_i (
    .a_i (x_biased),
    .b_i (y_biased),
    .p_o (raw_prod)
  );

  osm_bias_fix #(.WIDTH(WIDTH)) fix_i (
    .x_i    (x_in),
    .y_i    (y_in),
    .raw_i  (raw_prod),
    .prod_o (fixed_prod)
  );

  generate
    if (REGISTERED) begin : g_reg
      logic [PW-1:0] prod_q;
      always_ff @(posedge clk) begin
        if (rst) prod_q <= '0;
        else     prod_q <= fixed_prod;
      end
      assign prod_out = prod_q;

      assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (prod_out == '0))
        else $error("product not cleared by reset");

      assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (prod_out == $past(fixed_prod)))
        else $error("output stage latency wrong");
    end else begin : g_comb
      assign prod_out = fixed_prod;
    end
  endgenerate
endmodule

// File: tb/offset_signed_mult_tb_top.sv
module offset_signed_mult_tb_top;
  localparam int unsigned N  = 8;
  localparam int unsigned PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  x_in = '0;
  logic [N-1:0]  y_in = '0;
  logic [PW-1:0] prod_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  offset_signed_mult #(.WIDTH(N), .REGISTERED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .prod_out(prod_out)
  );

  function automatic logic [PW-1:0] golden(input logic [N-1:0] a, input logic [N-1:0] b);
    logic signed [PW-1:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%h expected=0x%h", req, got, exp);
    end
  endtask

  // Drive a pair at a falling edge, sample one falling edge later.
  task automatic apply(input string req, input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic [PW-1:0] exp);
    @(negedge clk);
    x_in = a; y_in = b;
    @(negedge clk);
    check(req, prod_out, exp);
  endtask

  task automatic t_reset_state();
    rst = 1'b1; x_in = 8'h7F; y_in = 8'h7F;
    @(negedge clk); @(negedge clk);
    check("R7 reset state", prod_out, '0);
    rst = 1'b0;
  endtask

  task automatic t_extremes();
    apply("R2 min*min", 8'h80, 8'h80, 16'h4000);
    apply("R3 min*max", 8'h80, 8'h7F, 16'hC080);
    apply("R3 max*min", 8'h7F, 8'h80, 16'hC080);
    apply("R1 max*max", 8'h7F, 8'h7F, 16'h3F01);
  endtask

  task automatic t_zero();
    apply("R4 zero*min", 8'h00, 8'h80, 16'h0000);
    apply("R4 max*zero", 8'h7F, 8'h00, 16'h0000);
    apply("R4 -1*zero",  8'hFF, 8'h00, 16'h0000);
  endtask

  task automatic t_known_pairs();
    apply("R5 -60*50", 8'hC4, 8'h32, 16'hF448);
    apply("R5 -3*3",   8'hFD, 8'h03, 16'hFFF7);
    apply("R1 -1*-1",  8'hFF, 8'hFF, 16'h0001);
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      logic [N-1:0] a;
      logic [N-1:0] b;
      a = N'($urandom);
      b = N'($urandom);
      apply("R1 random", a, b, golden(a, b));
      if (a != '0 && b != '0)
        check("R8 sign", {{(PW-1){1'b0}}, prod_out[PW-1]},
              {{(PW-1){1'b0}}, a[N-1] ^ b[N-1]});
    end
  endtask

  task automatic t_latency();
    @(negedge clk);
    x_in = 8'h05; y_in = 8'hFA;
    @(negedge clk);
    check("R6 first result", prod_out, golden(8'h05, 8'hFA));
    x_in = 8'h10; y_in = 8'h10;
    #1;
    check("R6 held until edge", prod_out, golden(8'h05, 8'hFA));
    @(negedge clk);
    check("R6 second result", prod_out, 16'h0100);
  endtask

  task automatic t_reset_midstream();
    @(negedge clk);
    x_in = 8'h80; y_in = 8'h80; rst = 1'b1;
    @(negedge clk);
    check("R7 reset midstream", prod_out, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 resume after reset", prod_out, 16'h4000);
  endtask

  initial begin
    t_reset_state();
    t_extremes();
    t_zero();
    t_known_pairs();
    t_latency();
    t_reset_midstream();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule